// File: doc/BRIEF.md
# Ping-Pong DMA Request Steering

This block sits between an acquisition FIFO's data-ready signal and a DMA controller that has several request lines (two in the default build). At any moment one channel is selected, and only that channel's request output follows the FIFO. Each channel writes into its own memory buffer. When a transfer that the controller acknowledges also carries the terminal-count indication, the selector moves on to the next channel. With two channels the buffers are therefore served in strict alternation, and software can empty one buffer while the other fills. No software has to reprogram the controller between buffers.

A sticky status flag records that a terminal count was seen. Software clears it with a dedicated strobe, or with the general acquisition clear, which also returns steering to channel 0. The index of the selected channel is exported so that software can tell which buffer is being filled.

Top module: `ppdma_steer`

## Requirements
- R1: While reset is held and on release, every request output is 0, `sel` is 0 and `tc_flag` is 0.
- R2: At most one bit of `dma_req` is 1, and a request bit that is 1 is always bit `sel`.
- R3: After a rising edge with `dma_en`=1, `fifo_rdy`=1 and `acq_clr`=0, the request bit of the channel selected after that edge is 1. The exception is when that same channel had request and acknowledge both 1 in the cycle before the edge.
- R4: After any edge with `dma_en`=0, all request outputs are 0 and `sel` is 0. Steering therefore restarts on channel 0 when enable returns.
- R5: After an edge where a channel's request and acknowledge are both 1 (an acknowledged transfer), that channel's request is 0 for the following cycle.
- R6: An acknowledged transfer with `dma_tc`=1 advances `sel` by one, wrapping from NUM_CH-1 to 0. With the default NUM_CH=2 it toggles 0↔1.
- R7: `dma_tc` in a cycle without an acknowledged transfer is ignored: `sel` and `tc_flag` do not change. An acknowledge on a channel whose request is 0 is ignored in the same way.
- R8: An acknowledged transfer with `dma_tc`=1 sets `tc_flag`, and the flag stays 1 until it is cleared.
- R9: `tc_clr`=1 clears `tc_flag` at the next edge. If a terminal-count transfer happens in the same cycle, the flag is set instead.
- R10: `acq_clr`=1 clears `tc_flag`, sets `sel` to 0 and drops all requests at the next edge. It overrides a simultaneous terminal-count transfer.
- R11: A run of terminal-count transfers serves the channels in the order 0,1,0,1,… with NUM_CH=2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_en | input | 1 | Enables request forwarding |
| fifo_rdy | input | 1 | FIFO has data ready to move |
| dma_ack | input | NUM_CH | Acknowledge from each DMA channel |
| dma_tc | input | 1 | Terminal count from the DMA controller |
| tc_clr | input | 1 | Strobe that clears the terminal-count flag |
| acq_clr | input | 1 | General acquisition clear strobe |
| dma_req | output | NUM_CH | Request to each DMA channel |
| sel | output | SEL_W | Index of the selected channel |
| tc_flag | output | 1 | Sticky terminal-count status |

## Verification
Directed sequences cover the following cases:
- A plain acknowledge, which drops the request but keeps the channel.
- An acknowledged terminal count, which hands the request to the other channel at once.
- A stray terminal count, with no acknowledge or with an acknowledge on an idle channel, which must change nothing.
- Collisions of the clear strobes with a terminal-count transfer, which show which one has priority.

A long random run then mixes enable, ready, acknowledge, terminal count and both clears at independent rates. Its results are compared each cycle against a reference model of the requirements. This exposes wrong ordering between the clear, set and advance rules that no single directed case reaches.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;

  // Action chosen for the terminal-count status flag in a cycle.
  typedef enum logic [1:0] {
    FLG_HOLD = 2'd0,
    FLG_SET  = 2'd1,
    FLG_CLR  = 2'd2
  } flag_op_e;

endpackage

// File: rtl/ppdma_sel.sv
module ppdma_sel #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             acq_clr,
  input  logic             adv,
  output logic [SEL_W-1:0] sel_q,
  output logic [SEL_W-1:0] sel_nxt
);

  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_CH - 1);

  logic sel_load;

  always_comb begin
    sel_nxt = sel_q;
    if (!en || acq_clr) begin
      sel_nxt = '0;
    end else if (adv) begin
      sel_nxt = (sel_q == LAST) ? '0 : sel_q + 1'b1;
    end
    sel_load = (sel_nxt != sel_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_load) begin
      sel_q <= sel_nxt;
    end
  end

endmodule

// File: rtl/ppdma_req_gate.sv
module ppdma_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  logic rdy,
  input  logic chosen,
  input  logic ack,
  output logic req_o,
  output logic xfer_o
);

  logic req_q;
  logic req_d;
  logic req_load;

  // A transfer happens only when this channel requests and is acknowledged.
  assign xfer_o = req_q & ack;

  always_comb begin
    req_d    = en & ~clr & rdy & chosen & ~xfer_o;
    req_load = (req_d != req_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
    end else if (req_load) begin
      req_q <= req_d;
    end
  end

  assign req_o = req_q;

endmodule

// File: rtl/ppdma_tc_flag.sv
module ppdma_tc_flag
  import ppdma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_tc,
  input  logic clr_all,
  output logic flag_q
);

  flag_op_e op;

  // General clear beats a hit; a hit beats the dedicated clear.
  always_comb begin
    if (clr_all) begin
      op = FLG_CLR;
    end else if (hit) begin
      op = FLG_SET;
    end else if (clr_tc) begin
      op = FLG_CLR;
    end else begin
      op = FLG_HOLD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (op != FLG_HOLD) begin
      flag_q <= (op == FLG_SET);
    end
  end

endmodule

// File: rtl/ppdma_steer.sv
module ppdma_steer #(
  parameter int unsigned NUM_CH = 2,
  localparam int unsigned SEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              fifo_rdy,
  input  logic [NUM_CH-1:0] dma_ack,
  input  logic              dma_tc,
  input  logic              tc_clr,
  input  logic              acq_clr,
  output logic [NUM_CH-1:0] dma_req,
  output logic [SEL_W-1:0]  sel,
  output logic              tc_flag
);

  logic [NUM_CH-1:0] xfer_v;
  logic [SEL_W-1:0]  sel_nxt;
  logic              tc_hit;

  // Terminal count only counts during an acknowledged transfer.
  assign tc_hit = (|xfer_v) & dma_tc;

  ppdma_sel #(
    .NUM_CH (NUM_CH),
    .SEL_W  (SEL_W)
  ) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (dma_en),
    .acq_clr (acq_clr),
    .adv     (tc_hit),
    .sel_q   (sel),
    .sel_nxt (sel_nxt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    ppdma_req_gate u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (dma_en),
      .clr    (acq_clr),
      .rdy    (fifo_rdy),
      .chosen (sel_nxt == SEL_W'(i)),
      .ack    (dma_ack[i]),
      .req_o  (dma_req[i]),
      .xfer_o (xfer_v[i])
    );
  end

  ppdma_tc_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (tc_hit),
    .clr_tc  (tc_clr),
    .clr_all (acq_clr),
    .flag_q  (tc_flag)
  );

endmodule

// File: rtl/ppdma_steer_chk.sv
module ppdma_steer_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dma_en,
  input logic              fifo_rdy,
  input logic [NUM_CH-1:0] dma_ack,
  input logic              dma_tc,
  input logic              tc_clr,
  input logic              acq_clr,
  input logic [NUM_CH-1:0] dma_req,
  input logic [SEL_W-1:0]  sel,
  input logic              tc_flag
);

  logic             xfer;
  logic             hit;
  logic [SEL_W-1:0] sel_succ;

  always_comb begin
    xfer     = |(dma_req & dma_ack);
    hit      = xfer & dma_tc;
    sel_succ = (sel == SEL_W'(NUM_CH - 1)) ? '0 : sel + 1'b1;
  end

  always_comb begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (dma_req == '0 && sel == '0 && tc_flag == 1'b0);
    end
  end

  assert_one_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req != '0) |-> ($onehot0(dma_req) && dma_req[sel]));

  assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> (dma_req == '0 && sel == '0));

  assert_ack_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> ((dma_req & $past(dma_req & dma_ack)) == '0));

  assert_tc_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && dma_en && !acq_clr) |=> (sel == $past(sel_succ)));

  assert_stray_tc_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer && dma_en && !acq_clr) |=> $stable(sel));

  assert_stray_tc_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !tc_clr && !acq_clr) |=> $stable(tc_flag));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !acq_clr) |=> tc_flag);

  assert_flag_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_clr && !hit) |=> !tc_flag);

  assert_acq_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acq_clr |=> (tc_flag == 1'b0 && sel == '0 && dma_req == '0));

endmodule

bind ppdma_steer ppdma_steer_chk #(
  .NUM_CH (NUM_CH),
  .SEL_W  (SEL_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dma_en   (dma_en),
  .fifo_rdy (fifo_rdy),
  .dma_ack  (dma_ack),
  .dma_tc   (dma_tc),
  .tc_clr   (tc_clr),
  .acq_clr  (acq_clr),
  .dma_req  (dma_req),
  .sel      (sel),
  .tc_flag  (tc_flag)
);

// File: tb/ppdma_steer_bench.sv
`timescale 1ns/1ps
module ppdma_steer_bench;

  localparam int unsigned NCH = 2;

  logic           clk;
  logic           rst_n;
  logic           dma_en;
  logic           fifo_rdy;
  logic [NCH-1:0] dma_ack;
  logic           dma_tc;
  logic           tc_clr;
  logic           acq_clr;
  logic [NCH-1:0] dma_req;
  logic [0:0]     sel;
  logic           tc_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Reference model state, built from the requirements.
  logic [NCH-1:0] m_req;
  logic [0:0]     m_sel;
  logic           m_flag;

  ppdma_steer #(.NUM_CH(NCH)) u_ppdma_steer (
    .clk      (clk),
    .rst_n    (rst_n),
    .dma_en   (dma_en),
    .fifo_rdy (fifo_rdy),
    .dma_ack  (dma_ack),
    .dma_tc   (dma_tc),
    .tc_clr   (tc_clr),
    .acq_clr  (acq_clr),
    .dma_req  (dma_req),
    .sel      (sel),
    .tc_flag  (tc_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [0:0] next_sel(logic [0:0] s, logic en, logic clr, logic hit);
    if (!en || clr) return 1'b0;
    if (hit) return ~s;
    return s;
  endfunction

  function automatic logic next_flag(logic f, logic clr, logic hit, logic tclr);
    if (clr) return 1'b0;
    if (hit) return 1'b1;
    if (tclr) return 1'b0;
    return f;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req  <= '0;
      m_sel  <= '0;
      m_flag <= 1'b0;
    end else begin
      logic [NCH-1:0] xf;
      logic           h;
      logic [0:0]     ns;
      xf = m_req & dma_ack;
      h  = (|xf) & dma_tc;
      ns = next_sel(m_sel, dma_en, acq_clr, h);
      for (int i = 0; i < NCH; i++) begin
        m_req[i] <= dma_en & ~acq_clr & fifo_rdy & (ns == i[0:0]) & ~xf[i];
      end
      m_sel  <= ns;
      m_flag <= next_flag(m_flag, acq_clr, h, tc_clr);
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic en, logic rdy, logic [NCH-1:0] ack, logic tc, logic tclr, logic aclr);
    dma_en   = en;
    fifo_rdy = rdy;
    dma_ack  = ack;
    dma_tc   = tc;
    tc_clr   = tclr;
    acq_clr  = aclr;
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic cmp_model(string tag);
    chk({tag, " req"}, 32'(dma_req), 32'(m_req));
    chk({tag, " sel"}, 32'(sel), 32'(m_sel));
    chk({tag, " flag"}, 32'(tc_flag), 32'(m_flag));
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    drive(0, 0, '0, 0, 0, 0);
    repeat (3) @(posedge clk);
    #2;
    chk("R1 req in reset", 32'(dma_req), 0);
    chk("R1 sel in reset", 32'(sel), 0);
    chk("R1 flag in reset", 32'(tc_flag), 0);
    rst_n = 1'b1;
    step();
    chk("R1 req after release", 32'(dma_req), 0);

    // R3: enable with data ready -> channel 0 requests
    drive(1, 1, '0, 0, 0, 0);
    step();
    chk("R3 ch0 request", 32'(dma_req), 1);
    chk("R3 sel 0", 32'(sel), 0);

    // R5: plain acknowledge drops the request, channel kept
    drive(1, 1, 2'b01, 0, 0, 0);
    step();
    chk("R5 request dropped", 32'(dma_req), 0);
    chk("R5 sel kept", 32'(sel), 0);
    drive(1, 1, '0, 0, 0, 0);
    step();
    chk("R3 request again", 32'(dma_req), 1);

    // R6/R8: acknowledged terminal count moves to channel 1
    drive(1, 1, 2'b01, 1, 0, 0);
    step();
    chk("R6 sel advanced", 32'(sel), 1);
    chk("R2 ch1 request", 32'(dma_req), 2);
    chk("R8 flag set", 32'(tc_flag), 1);

    // R7: stray tc with no ack, and ack on idle channel 0 with tc
    drive(1, 1, '0, 1, 0, 0);
    step();
    chk("R7 stray tc sel", 32'(sel), 1);
    drive(1, 1, 2'b01, 1, 1, 0);
    step();
    chk("R7 idle ack sel", 32'(sel), 1);
    chk("R7 idle ack req", 32'(dma_req), 2);
    chk("R9 flag cleared", 32'(tc_flag), 0);
    drive(1, 1, '0, 1, 0, 0);
    step();
    chk("R7 stray tc flag", 32'(tc_flag), 0);

    // R9: set wins over dedicated clear
    drive(1, 1, 2'b10, 1, 1, 0);
    step();
    chk("R9 set beats clear", 32'(tc_flag), 1);
    chk("R6 wrap to 0", 32'(sel), 0);
    drive(1, 1, '0, 0, 0, 0);
    step();
    chk("R8 flag sticky", 32'(tc_flag), 1);

    // R11: alternation over repeated terminal counts
    for (int k = 0; k < 4; k++) begin
      drive(1, 1, (sel == 1'b0) ? 2'b01 : 2'b10, 1, 0, 0);
      step();
      chk("R11 alternation", 32'(sel), 32'((k + 1) % 2));
    end

    // R10: acq_clr overrides a terminal-count transfer
    chk("R10 precondition sel", 32'(sel), 0);
    drive(1, 1, 2'b01, 1, 0, 1);
    step();
    chk("R10 sel to 0", 32'(sel), 0);
    chk("R10 flag cleared", 32'(tc_flag), 0);
    chk("R10 req dropped", 32'(dma_req), 0);

    // R4: disable drops requests and resets the selector
    drive(1, 1, 2'b01, 1, 0, 0);
    step();
    step();
    chk("R4 precondition sel", 32'(sel), 1);
    drive(0, 1, '0, 0, 0, 0);
    step();
    chk("R4 req off", 32'(dma_req), 0);
    chk("R4 sel 0", 32'(sel), 0);
    drive(1, 1, '0, 0, 0, 0);
    step();
    chk("R4 restart on ch0", 32'(dma_req), 1);
    cmp_model("R2 model sync");

    // Random phase against the model
    for (int n = 0; n < 3000; n++) begin
      drive(($urandom % 20) != 0, ($urandom % 5) != 0, NCH'($urandom),
            ($urandom % 3) == 0, ($urandom % 10) == 0, ($urandom % 40) == 0);
      step();
      cmp_model("R3/R6/R8 random");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule